// File: doc/BRIEF.md
# Indexed Block Register Slave on a Two-Wire Management Bus

This block sits on a two-wire management bus (SMBus electrical and framing conventions) as a slave device. It holds a small configuration register file of fifteen bytes and lets a bus host reach it with indexed block transfers. To write, the host addresses the device, gives a starting index and a byte count, and then streams that many data bytes. Each data byte lands at the next index. To read, the host addresses the device for writing and sets the starting index. It then issues a repeated start and re-addresses the device for reading. The device answers with a byte count taken from its own count register, and then streams register contents from the starting index for as long as the host acknowledges.

Both bus lines are oversampled by the system clock through two-flop synchronizers. The device only pulls the data line low and never drives it high, so the board resistor does the pull-up. Inside the chip, the block reports every accepted data byte on a write-notification port. A separate combinational lookup port lets neighbouring logic read any register by index.

Top module: `smb_idx_slave`

## Requirements
- R1: After reset the data line is released (sda_pull low). Index 5 holds 0x08, index 6 holds 0x07, index 4 holds {REV_ID, VEND_ID} (0x01 by default), and every other index holds 0x00.
- R2: The device acknowledges (pulls data low through the ninth clock) an address byte whose upper seven bits equal 0x6E: 0xDC selects write and 0xDD selects read. Any other address is not acknowledged, and the device then ignores the bus (no acknowledge, no write) until the next start.
- R3: A write transfer is start, 0xDC, index N, count X, then data bytes. Each of the first X data bytes is acknowledged, stored at N, N+1, ... in turn, and announced by a one-cycle cfg_wr_stb with its index and data.
- R4: Data bytes after the first X of a write transfer are not acknowledged, not stored and not announced.
- R5: A read transfer is start, 0xDC, N, repeated start, 0xDD. The device first sends the byte-count register (index 6) and then the contents of N, N+1, ... one byte per host acknowledge, most significant bit first. After the host's NACK it releases the data line.
- R6: Index 4 is read-only. Indices 7 and 8 read as 0x00. Any index of 15 or more reads as 0x00. Writes to all of these leave what they read unchanged.
- R7: The byte-count register at index 6 is writable, and its value is the first byte of every later read transfer.
- R8: The device-ID register at index 5 is writable like any plain register.
- R9: A repeated start, even after a non-matching address, restarts address decoding. A stop returns the device to idle.
- R10: cfg_rd_data always shows the register at cfg_rd_idx, including values written over the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | High to pull the data line low (open drain) |
| cfg_wr_stb | output | 1 | One-cycle pulse per accepted data byte |
| cfg_wr_idx | output | 8 | Index of the accepted data byte |
| cfg_wr_data | output | 8 | Value of the accepted data byte |
| cfg_rd_idx | input | 8 | Lookup index from neighbouring logic |
| cfg_rd_data | output | 8 | Register contents at cfg_rd_idx |

## Verification
The bench sends a write that carries more data than its count. A design that ignored the count would acknowledge and store the extra byte, and the scoreboard would see an unexpected strobe. It writes across the read-only, reserved and unimplemented indices, and then reads them back both over the bus and through the lookup port. A design that stored those bytes would return them instead of the fixed ID or zero. It sends a foreign address followed by a repeated start to the right address. A design that stayed deaf after the mismatch would miss the second transfer, and one that answered the mismatch would show an acknowledge. It also reprograms the count register and checks that the first byte of a read follows the new value, which exposes a design that returns a hard-wired count.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_WDATA,
    PH_RCOUNT,
    PH_RDATA,
    PH_SKIP
  } smb_phase_e;

  // register positions that the protocol or neighbours depend on
  localparam int IDX_VID  = 4;
  localparam int IDX_DID  = 5;
  localparam int IDX_CNT  = 6;
  localparam int IDX_RSV0 = 7;
  localparam int IDX_RSV1 = 8;

  localparam int BYTE_W   = 8;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int LINES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pad_in,
  output logic [LINES-1:0] now_q,
  output logic [LINES-1:0] prev_q
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
        last_q <= 1'b1;
      end else begin
        meta_q <= pad_in[g];
        sync_q <= meta_q;
        last_q <= sync_q;
      end
    end

    assign now_q[g]  = sync_q;
    assign prev_q[g] = last_q;
  end

endmodule

// File: rtl/smb_cond_det.sv
module smb_cond_det (
  input  logic scl_now,
  input  logic scl_prev,
  input  logic sda_now,
  input  logic sda_prev,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_hit,
  output logic stop_hit
);

  logic scl_held;

  assign scl_held  = scl_now & scl_prev;
  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  // data edges while the clock stays high mark bus conditions
  assign start_hit = scl_held & sda_prev & ~sda_now;
  assign stop_hit  = scl_held & ~sda_prev & sda_now;

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_pkg::*;
#(
  parameter int         NUM_REGS  = 15,
  parameter logic [3:0] REV_ID    = 4'h0,
  parameter logic [3:0] VEND_ID   = 4'h1,
  parameter logic [7:0] DEVID_RST = 8'h08,
  parameter logic [7:0] COUNT_RST = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rd_a_idx,
  output logic [BYTE_W-1:0] rd_a_data,
  input  logic [BYTE_W-1:0] rd_b_idx,
  output logic [BYTE_W-1:0] rd_b_data,
  output logic [BYTE_W-1:0] count_val
);

  localparam int IW    = $clog2(NUM_REGS);
  localparam int DEPTH = 1 << IW;

  logic [BYTE_W-1:0] rf_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    if (i >= NUM_REGS) begin : g_absent
      assign rf_q[i] = '0;
    end else if (i == IDX_VID) begin : g_ident
      assign rf_q[i] = {REV_ID, VEND_ID};
    end else if (i == IDX_RSV0 || i == IDX_RSV1) begin : g_rsv
      assign rf_q[i] = '0;
    end else begin : g_store
      localparam logic [BYTE_W-1:0] RST_V =
        (i == IDX_DID) ? DEVID_RST : (i == IDX_CNT) ? COUNT_RST : '0;
      logic [BYTE_W-1:0] val_q;
      logic              hit;

      assign hit = wr_en && (wr_idx == BYTE_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   val_q <= RST_V;
        else if (hit) val_q <= wr_data;
      end

      assign rf_q[i] = val_q;
    end
  end

  assign rd_a_data = (rd_a_idx < BYTE_W'(NUM_REGS)) ? rf_q[rd_a_idx[IW-1:0]] : '0;
  assign rd_b_data = (rd_b_idx < BYTE_W'(NUM_REGS)) ? rf_q[rd_b_idx[IW-1:0]] : '0;
  assign count_val = rf_q[IDX_CNT];

endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_hit,
  input  logic              stop_hit,
  input  logic              sda_now,
  input  logic [BYTE_W-1:0] rf_rd_data,
  input  logic [BYTE_W-1:0] count_val,
  output logic [BYTE_W-1:0] rf_rd_idx,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_pull
);

  smb_phase_e        phase_q, phase_d;
  logic [3:0]        bit_q, bit_d;
  logic              in_ack_q, in_ack_d;
  logic              ack_q, ack_d;
  logic              tx_q, tx_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [BYTE_W-1:0] txb_q, txb_d;
  logic [BYTE_W-1:0] idx_q, idx_d;
  logic [BYTE_W-1:0] left_q, left_d;
  logic              pull_q, pull_d;
  logic              stb_q, stb_d;
  logic [BYTE_W-1:0] widx_q, widx_d;
  logic [BYTE_W-1:0] wdat_q, wdat_d;

  logic [BYTE_W-1:0] rx_byte;
  logic [BYTE_W-1:0] next_tx;
  logic [2:0]        tx_pos;

  assign rx_byte = {shreg_q[BYTE_W-2:0], sda_now};
  assign tx_pos  = 3'd7 - bit_q[2:0];
  assign next_tx = (phase_q == PH_RCOUNT) ? count_val : rf_rd_data;

  always_comb begin
    phase_d  = phase_q;
    bit_d    = bit_q;
    in_ack_d = in_ack_q;
    ack_d    = ack_q;
    tx_d     = tx_q;
    shreg_d  = shreg_q;
    txb_d    = txb_q;
    idx_d    = idx_q;
    left_d   = left_q;
    pull_d   = pull_q;
    stb_d    = 1'b0;
    widx_d   = widx_q;
    wdat_d   = wdat_q;

    if (stop_hit || start_hit) begin
      phase_d  = stop_hit ? PH_IDLE : PH_ADDR;
      bit_d    = '0;
      in_ack_d = 1'b0;
      ack_d    = 1'b0;
      tx_d     = 1'b0;
      pull_d   = 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (scl_rise) begin
        if (!in_ack_q) begin
          bit_d = bit_q + 4'd1;
          if (!tx_q) begin
            shreg_d = rx_byte;
            if (bit_q == 4'd7) begin
              ack_d = 1'b0;
              unique case (phase_q)
                PH_ADDR: begin
                  if (rx_byte[7:1] == DEV_ADDR) begin
                    ack_d   = 1'b1;
                    phase_d = rx_byte[0] ? PH_RCOUNT : PH_INDEX;
                  end else begin
                    phase_d = PH_SKIP;
                  end
                end
                PH_INDEX: begin
                  idx_d   = rx_byte;
                  ack_d   = 1'b1;
                  phase_d = PH_COUNT;
                end
                PH_COUNT: begin
                  left_d  = rx_byte;
                  ack_d   = 1'b1;
                  phase_d = PH_WDATA;
                end
                PH_WDATA: begin
                  if (left_q != '0) begin
                    ack_d  = 1'b1;
                    stb_d  = 1'b1;
                    widx_d = idx_q;
                    wdat_d = rx_byte;
                    idx_d  = idx_q + 8'd1;
                    left_d = left_q - 8'd1;
                  end else begin
                    phase_d = PH_SKIP;
                  end
                end
                default: phase_d = phase_q;
              endcase
            end
          end
        end else if (tx_q) begin
          // host acknowledge slot of a transmitted byte
          if (!sda_now && phase_q != PH_SKIP) begin
            if (phase_q == PH_RCOUNT) phase_d = PH_RDATA;
            else                      idx_d   = idx_q + 8'd1;
          end else begin
            phase_d = PH_SKIP;
          end
        end
      end else if (scl_fall) begin
        if (!in_ack_q) begin
          if (bit_q == 4'd8) begin
            in_ack_d = 1'b1;
            pull_d   = tx_q ? 1'b0 : ack_q;
          end else if (tx_q && phase_q != PH_SKIP && bit_q != 4'd0) begin
            pull_d = ~txb_q[tx_pos];
          end
        end else begin
          in_ack_d = 1'b0;
          bit_d    = '0;
          ack_d    = 1'b0;
          if (phase_q == PH_RCOUNT || phase_q == PH_RDATA) begin
            tx_d   = 1'b1;
            txb_d  = next_tx;
            pull_d = ~next_tx[7];
          end else begin
            tx_d   = 1'b0;
            pull_d = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      bit_q    <= '0;
      in_ack_q <= 1'b0;
      ack_q    <= 1'b0;
      tx_q     <= 1'b0;
      shreg_q  <= '0;
      txb_q    <= '0;
      idx_q    <= '0;
      left_q   <= '0;
      pull_q   <= 1'b0;
      stb_q    <= 1'b0;
      widx_q   <= '0;
      wdat_q   <= '0;
    end else begin
      phase_q  <= phase_d;
      bit_q    <= bit_d;
      in_ack_q <= in_ack_d;
      ack_q    <= ack_d;
      tx_q     <= tx_d;
      shreg_q  <= shreg_d;
      txb_q    <= txb_d;
      idx_q    <= idx_d;
      left_q   <= left_d;
      pull_q   <= pull_d;
      stb_q    <= stb_d;
      widx_q   <= widx_d;
      wdat_q   <= wdat_d;
    end
  end

  assign rf_rd_idx = idx_q;
  assign wr_stb    = stb_q;
  assign wr_idx    = widx_q;
  assign wr_data   = wdat_q;
  assign sda_pull  = pull_q;

endmodule

// File: rtl/smb_idx_slave.sv
module smb_idx_slave
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h6E,
  parameter int         NUM_REGS  = 15,
  parameter logic [3:0] REV_ID    = 4'h0,
  parameter logic [3:0] VEND_ID   = 4'h1,
  parameter logic [7:0] DEVID_RST = 8'h08,
  parameter logic [7:0] COUNT_RST = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  output logic       cfg_wr_stb,
  output logic [7:0] cfg_wr_idx,
  output logic [7:0] cfg_wr_data,
  input  logic [7:0] cfg_rd_idx,
  output logic [7:0] cfg_rd_data
);

  logic [1:0] line_now, line_prev;
  logic       scl_rise, scl_fall, start_hit, stop_hit;
  logic [7:0] proto_idx, proto_data, count_val;

  smb_line_sync #(.LINES(2)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_in ({sda_in, scl_in}),
    .now_q  (line_now),
    .prev_q (line_prev)
  );

  smb_cond_det cond_i (
    .scl_now   (line_now[0]),
    .scl_prev  (line_prev[0]),
    .sda_now   (line_now[1]),
    .sda_prev  (line_prev[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_hit (start_hit),
    .stop_hit  (stop_hit)
  );

  smb_proto_fsm #(.DEV_ADDR(DEV_ADDR)) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_hit  (start_hit),
    .stop_hit   (stop_hit),
    .sda_now    (line_now[1]),
    .rf_rd_data (proto_data),
    .count_val  (count_val),
    .rf_rd_idx  (proto_idx),
    .wr_stb     (cfg_wr_stb),
    .wr_idx     (cfg_wr_idx),
    .wr_data    (cfg_wr_data),
    .sda_pull   (sda_pull)
  );

  smb_regfile #(
    .NUM_REGS  (NUM_REGS),
    .REV_ID    (REV_ID),
    .VEND_ID   (VEND_ID),
    .DEVID_RST (DEVID_RST),
    .COUNT_RST (COUNT_RST)
  ) rf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_stb),
    .wr_idx    (cfg_wr_idx),
    .wr_data   (cfg_wr_data),
    .rd_a_idx  (proto_idx),
    .rd_a_data (proto_data),
    .rd_b_idx  (cfg_rd_idx),
    .rd_b_data (cfg_rd_data),
    .count_val (count_val)
  );

endmodule

// File: rtl/smb_idx_slave_chk.sv
module smb_idx_slave_chk #(
  parameter int         NUM_REGS = 15,
  parameter logic [3:0] REV_ID   = 4'h0,
  parameter logic [3:0] VEND_ID  = 4'h1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       sda_pull,
  input logic       cfg_wr_stb,
  input logic [7:0] cfg_rd_idx,
  input logic [7:0] cfg_rd_data
);

  // R1: the data line stays released while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_released_in_reset_R1: assert (sda_pull == 1'b0)
        else $error("sda pulled during reset");
    end
  end

  // R2: the device moves the data line only while the bus clock is low
  assert_pull_moves_clk_low_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_in);

  // R3: each accepted byte gives a single-cycle notification
  assert_strobe_single_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    cfg_wr_stb |=> !cfg_wr_stb);

  // R6: identity byte is fixed whatever the bus wrote
  assert_ident_fixed_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    (cfg_rd_idx == 8'd4) |-> (cfg_rd_data == {REV_ID, VEND_ID}));

  // R6: unimplemented indices read zero
  assert_absent_zero_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    (cfg_rd_idx >= 8'(NUM_REGS)) |-> (cfg_rd_data == 8'h00));

endmodule

bind smb_idx_slave smb_idx_slave_chk #(
  .NUM_REGS (NUM_REGS),
  .REV_ID   (REV_ID),
  .VEND_ID  (VEND_ID)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_in      (scl_in),
  .sda_pull    (sda_pull),
  .cfg_wr_stb  (cfg_wr_stb),
  .cfg_rd_idx  (cfg_rd_idx),
  .cfg_rd_data (cfg_rd_data)
);

// File: tb/smb_idx_slave_tb_top.sv
module smb_idx_slave_tb_top;

  localparam int Q = 10;

  logic       clk;
  logic       rst_n;
  logic       scl_h;
  logic       sda_h;
  logic       sda_line;
  logic       sda_pull;
  logic       cfg_wr_stb;
  logic [7:0] cfg_wr_idx;
  logic [7:0] cfg_wr_data;
  logic [7:0] cfg_rd_idx;
  logic [7:0] cfg_rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct packed {
    logic [7:0] idx;
    logic [7:0] dat;
  } wr_item_t;

  wr_item_t exp_q[$];

  assign sda_line = sda_h & ~sda_pull;

  smb_idx_slave dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_in      (scl_h),
    .sda_in      (sda_line),
    .sda_pull    (sda_pull),
    .cfg_wr_stb  (cfg_wr_stb),
    .cfg_wr_idx  (cfg_wr_idx),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_idx  (cfg_rd_idx),
    .cfg_rd_data (cfg_rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor on the write-notification port
  always @(negedge clk) begin
    if (rst_n && cfg_wr_stb) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4: actual write %h<=%h expected none", cfg_wr_idx, cfg_wr_data);
      end else begin
        wr_item_t e;
        e = exp_q.pop_front();
        if (cfg_wr_idx !== e.idx || cfg_wr_data !== e.dat) begin
          errors++;
          $display("FAIL R3: actual write %h<=%h expected %h<=%h",
                   cfg_wr_idx, cfg_wr_data, e.idx, e.dat);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic h_start();
    sda_h = 1'b1; tick(Q);
    scl_h = 1'b1; tick(Q);
    sda_h = 1'b0; tick(Q);
    scl_h = 1'b0; tick(Q);
  endtask

  task automatic h_stop();
    sda_h = 1'b0; tick(Q);
    scl_h = 1'b1; tick(Q);
    sda_h = 1'b1; tick(Q);
  endtask

  task automatic h_bit(input logic b, output logic smp);
    sda_h = b;    tick(Q);
    scl_h = 1'b1; tick(Q);
    smp = sda_line; tick(Q);
    scl_h = 1'b0; tick(Q);
  endtask

  task automatic h_send(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) h_bit(v[i], s);
    h_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic h_recv(input logic nack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      h_bit(1'b1, s);
      v[i] = s;
    end
    h_bit(nack, s);
  endtask

  // indexed block write; bytes past the count must be refused
  task automatic do_write(string req, logic [7:0] n, logic [7:0] x,
                          logic [7:0] d [8], int nd);
    logic ack;
    h_start();
    h_send(8'hDC, ack); chk8({req, " addr ack"}, {7'd0, ack}, 8'd1);
    h_send(n, ack);     chk8({req, " index ack"}, {7'd0, ack}, 8'd1);
    h_send(x, ack);     chk8({req, " count ack"}, {7'd0, ack}, 8'd1);
    for (int k = 0; k < nd; k++) begin
      wr_item_t it;
      if (k < int'(x)) begin
        it.idx = n + 8'(k);
        it.dat = d[k];
        exp_q.push_back(it);
      end
      h_send(d[k], ack);
      chk8((k < int'(x)) ? {req, " data ack"} : "R4 extra byte ack",
           {7'd0, ack}, (k < int'(x)) ? 8'd1 : 8'd0);
    end
    h_stop();
    tick(4);
  endtask

  // indexed block read; exp[0] is the count byte
  task automatic do_read(string req, logic [7:0] n, logic [7:0] exp [9], int m);
    logic ack;
    logic [7:0] v;
    h_start();
    h_send(8'hDC, ack); chk8("R2 read setup ack", {7'd0, ack}, 8'd1);
    h_send(n, ack);     chk8("R5 index ack", {7'd0, ack}, 8'd1);
    h_start();
    h_send(8'hDD, ack); chk8("R2 read addr ack", {7'd0, ack}, 8'd1);
    for (int k = 0; k < m; k++) begin
      h_recv(k == m - 1, v);
      chk8(req, v, exp[k]);
    end
    h_stop();
    tick(4);
    chk8("R5 line released", {7'd0, sda_pull}, 8'd0);
  endtask

  task automatic peek(string req, logic [7:0] idx, logic [7:0] exp);
    cfg_rd_idx = idx;
    tick(1);
    chk8(req, cfg_rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    logic ack;
    rst_n = 1'b0;
    scl_h = 1'b1;
    sda_h = 1'b1;
    cfg_rd_idx = 8'd0;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1 reset state and R10 lookup port
    chk8("R1 sda released", {7'd0, sda_pull}, 8'd0);
    peek("R1 idx0", 8'd0, 8'h00);
    peek("R1 ident idx4", 8'd4, 8'h01);
    peek("R1 devid idx5", 8'd5, 8'h08);
    peek("R1 count idx6", 8'd6, 8'h07);
    peek("R1 idx14", 8'd14, 8'h00);

    // R3 basic block write
    do_write("R3", 8'd0, 8'd3, '{8'hA1, 8'hB2, 8'hC3, 0, 0, 0, 0, 0}, 3);
    peek("R10 idx0", 8'd0, 8'hA1);
    peek("R10 idx2", 8'd2, 8'hC3);

    // R5 read with default count
    do_read("R5 read data", 8'd0,
            '{8'h07, 8'hA1, 8'hB2, 8'hC3, 8'h00, 8'h01, 8'h08, 8'h07, 8'h00}, 8);

    // R4 more data than the count
    do_write("R4", 8'd9, 8'd2, '{8'h11, 8'h22, 8'h33, 0, 0, 0, 0, 0}, 3);
    peek("R4 idx9", 8'd9, 8'h11);
    peek("R4 idx10", 8'd10, 8'h22);
    peek("R4 idx11 untouched", 8'd11, 8'h00);

    // R2 foreign address, then R9 repeated start to the right one
    h_start();
    h_send(8'hA0, ack); chk8("R2 foreign addr nack", {7'd0, ack}, 8'd0);
    h_send(8'h00, ack); chk8("R2 ignored byte nack", {7'd0, ack}, 8'd0);
    h_start();
    h_send(8'hDC, ack); chk8("R9 restart addr ack", {7'd0, ack}, 8'd1);
    h_send(8'd12, ack); chk8("R9 index ack", {7'd0, ack}, 8'd1);
    h_send(8'd1, ack);  chk8("R9 count ack", {7'd0, ack}, 8'd1);
    exp_q.push_back('{idx: 8'd12, dat: 8'h5C});
    h_send(8'h5C, ack); chk8("R9 data ack", {7'd0, ack}, 8'd1);
    h_stop();
    tick(4);
    peek("R9 idx12", 8'd12, 8'h5C);

    // R6 R7 R8 write across fixed and plain registers
    do_write("R6", 8'd3, 8'd6, '{8'h5A, 8'h66, 8'h77, 8'h88, 8'h99, 8'hAA, 0, 0}, 6);
    peek("R6 idx3", 8'd3, 8'h5A);
    peek("R6 ident kept", 8'd4, 8'h01);
    peek("R8 devid written", 8'd5, 8'h77);
    peek("R7 count written", 8'd6, 8'h88);
    peek("R6 reserved idx7", 8'd7, 8'h00);
    peek("R6 reserved idx8", 8'd8, 8'h00);

    // R7 count register drives the first read byte
    do_write("R7", 8'd6, 8'd1, '{8'h03, 0, 0, 0, 0, 0, 0, 0}, 1);
    do_read("R7 read with new count", 8'd0,
            '{8'h03, 8'hA1, 8'hB2, 8'hC3, 0, 0, 0, 0, 0}, 4);

    // R6 past the last implemented index
    do_write("R6 edge", 8'd14, 8'd2, '{8'hE1, 8'hE2, 0, 0, 0, 0, 0, 0}, 2);
    peek("R6 idx14", 8'd14, 8'hE1);
    peek("R6 idx15 zero", 8'd15, 8'h00);
    do_read("R6 read edge", 8'd13,
            '{8'h03, 8'h00, 8'hE1, 8'h00, 0, 0, 0, 0, 0}, 4);
    do_read("R6 read fixed", 8'd4,
            '{8'h03, 8'h01, 8'h77, 8'h03, 8'h00, 0, 0, 0, 0}, 5);

    tick(10);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3: actual %0d writes missing expected 0", exp_q.size());
    end

    done = 1;
    report();
    $finish;
  end

endmodule